// File: doc/BRIEF.md
# SDRAM Command Protocol Monitor

This block sits passively beside the command pins of a single-data-rate SDRAM interface and flags command sequences that break the device's ordering and spacing rules. It decodes chip select, row strobe, column strobe and write enable on every rising clock edge. It tracks which of the banks are open, and it keeps per-bank elapsed-cycle timers for the activate and precharge events. From these it raises one of ten numbered rule violations. All timing limits are parameters expressed in clock cycles.

The monitor never drives the memory bus. A violation shows up one cycle after the offending command edge, in two forms. The first is a single-cycle pulse that carries the number of the lowest-numbered rule broken. The second is a sticky vector with one bit per rule, which holds every bit set until reset. Any command the monitor sees, including one that breaks a rule, updates the tracked bank state. The exception is a command that arrives while the clock enable was low on the previous edge: that command is treated as not accepted and changes nothing.

Top module: `sdram_proto_monitor`

## Requirements
- R1: A cycle with chip select high is a deselect and never raises a violation, whatever the strobe, bank and A10 inputs carry. A cycle with chip select low and row, column and write strobes all high is a NOP and never raises a violation.
- R2: A command other than NOP or deselect whose previous sampled clock enable was low raises rule 0. The monitor then discards that command and it updates no bank or timer state.
- R3: A mode register set (strobes L,L,L) or refresh (L,L,H) issued while any bank is open raises rule 2.
- R4: Any command other than NOP or deselect issued fewer than MRS_GAP cycles after a mode register set raises rule 1. A command issued exactly MRS_GAP cycles later is legal.
- R5: A read (H,L,H) or write (H,L,L) to an open bank fewer than T_RCD cycles after that bank's activate raises rule 5.
- R6: An activate (L,H,H) fewer than T_RRD cycles after the previous activate raises rule 6. An activate exactly T_RRD cycles later is legal.
- R7: A precharge (L,H,L) that hits an open bank fewer than T_RAS cycles after that bank's activate raises rule 7.
- R8: An activate fewer than T_RP cycles after that bank was precharged raises rule 8. An activate exactly T_RP cycles later is legal.
- R9: A precharge with A10 high closes every bank regardless of the bank address. With A10 low it closes only the bank the bank address selects.
- R10: A read or write with A10 high starts an auto-precharge burst of BURST_LEN cycles. Any read or write in the BURST_LEN-1 cycles after it raises rule 9. The bank closes when the burst ends, and an activate of that bank fewer than T_RP cycles after that point raises rule 8.
- R11: A read or write to a closed bank raises rule 3. An activate to a bank that is already open raises rule 4.
- R12: The violation pulse and code are registered: they appear in the cycle after the offending command edge, and the code is the lowest-numbered rule broken on that edge. Each bit of the sticky vector (bit n = rule n) stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory interface clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row address strobe, active low |
| cas_n | input | 1 | Column address strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank address |
| a10 | input | 1 | Address bit 10: all-bank precharge or auto-precharge flag |
| err_sticky | output | NRULE (10) | One bit per rule, held until reset |
| err_pulse | output | 1 | High for one cycle when any rule broke on the previous edge |
| err_code | output | 4 | Lowest-numbered rule broken on the previous edge |

## Verification
A single command edge often breaks more than one rule. For example, a read to a closed bank sent just after a mode register set breaks both the mode-set gap rule and the closed-bank rule. An activate sent one cycle after another activate, to a bank precharged one cycle earlier, breaks both the row-to-row rule and the precharge-recovery rule. The bench builds such edges on purpose and expects the pulse code to name only the lower-numbered rule, while the sticky vector collects both bits. A second collision comes from the auto-precharge burst ending on its own in the same stretch where the bench sends new commands: the bench places an activate in the first cycle after the burst and expects the recovery violation, which shows that the burst end, not the command, started the precharge timer.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [3:0] {
        OP_DESEL,
        OP_NOP,
        OP_MRS,
        OP_REF,
        OP_ACT,
        OP_PRE,
        OP_RD,
        OP_WR,
        OP_BST
    } op_e;

    localparam int NRULE  = 10;
    localparam int CODE_W = $clog2(NRULE);

    localparam int RL_CKE     = 0;
    localparam int RL_MRS_GAP = 1;
    localparam int RL_ALLPRE  = 2;
    localparam int RL_CLOSED  = 3;
    localparam int RL_REOPEN  = 4;
    localparam int RL_RCD     = 5;
    localparam int RL_RRD     = 6;
    localparam int RL_RAS     = 7;
    localparam int RL_RP      = 8;
    localparam int RL_APLOCK  = 9;

    function automatic op_e decode_cmd(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
        op_e r;
        if (cs_n) begin
            r = OP_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  r = OP_MRS;
                3'b001:  r = OP_REF;
                3'b011:  r = OP_ACT;
                3'b010:  r = OP_PRE;
                3'b101:  r = OP_RD;
                3'b100:  r = OP_WR;
                3'b110:  r = OP_BST;
                default: r = OP_NOP;
            endcase
        end
        return r;
    endfunction

    function automatic logic is_real(input op_e op);
        return (op != OP_NOP) && (op != OP_DESEL);
    endfunction

    function automatic logic is_rw(input op_e op);
        return (op == OP_RD) || (op == OP_WR);
    endfunction

    function automatic logic [CODE_W-1:0] lowest_rule(input logic [NRULE-1:0] v);
        logic [CODE_W-1:0] c;
        c = '0;
        for (int i = NRULE - 1; i >= 0; i--) begin
            if (v[i]) c = CODE_W'(i);
        end
        return c;
    endfunction

endpackage

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
    import sdram_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output op_e  op_acc,
    output logic v_cke
);
    logic cke_q;
    op_e  raw_op;

    always_ff @(posedge clk) begin
        if (rst) cke_q <= 1'b1;
        else     cke_q <= cke;
    end

    always_comb begin
        raw_op = decode_cmd(cs_n, ras_n, cas_n, we_n);
        v_cke  = is_real(raw_op) && !cke_q;
        op_acc = cke_q ? raw_op : OP_NOP;
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_mon_pkg::*;
#(
    parameter int CW        = 3,
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 5,
    parameter int T_RP      = 3,
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    input  logic sel,
    input  logic a10,
    output logic open_o,
    output logic ap_busy_o,
    output logic v_closed,
    output logic v_reopen,
    output logic v_rcd,
    output logic v_ras,
    output logic v_rp
);
    localparam int AW = $clog2(BURST_LEN + 1);
    localparam logic [CW-1:0] CMAX  = '1;
    localparam logic [CW-1:0] RCD_L = CW'(T_RCD);
    localparam logic [CW-1:0] RAS_L = CW'(T_RAS);
    localparam logic [CW-1:0] RP_L  = CW'(T_RP);
    localparam logic [AW-1:0] AP_INIT = AW'(BURST_LEN - 1);

    logic          open_q;
    logic [CW-1:0] act_cnt, pre_cnt;
    logic [AW-1:0] ap_rem;
    logic          act_hit, pre_hit, rw_hit, ap_end;

    always_comb begin
        act_hit  = (op == OP_ACT) && sel;
        pre_hit  = (op == OP_PRE) && (a10 || sel);
        rw_hit   = is_rw(op) && sel;
        ap_end   = (ap_rem == AW'(1));
        v_closed = rw_hit && !open_q;
        v_rcd    = rw_hit && open_q && (act_cnt < RCD_L);
        v_reopen = act_hit && open_q;
        v_rp     = act_hit && (pre_cnt < RP_L);
        v_ras    = pre_hit && open_q && (act_cnt < RAS_L);
        open_o    = open_q;
        ap_busy_o = (ap_rem != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            act_cnt <= CMAX;
            pre_cnt <= CMAX;
            ap_rem  <= '0;
        end else begin
            if (act_cnt != CMAX) act_cnt <= act_cnt + 1'b1;
            if (pre_cnt != CMAX) pre_cnt <= pre_cnt + 1'b1;
            if (ap_rem != '0)    ap_rem  <= ap_rem - 1'b1;
            if (ap_end) begin
                open_q  <= 1'b0;
                pre_cnt <= '0;
            end
            if (act_hit) begin
                open_q  <= 1'b1;
                act_cnt <= CW'(1);
            end
            if (pre_hit) begin
                open_q  <= 1'b0;
                pre_cnt <= CW'(1);
                ap_rem  <= '0;
            end
            if (rw_hit && a10) begin
                if (BURST_LEN == 1) begin
                    open_q  <= 1'b0;
                    pre_cnt <= '0;
                end else begin
                    ap_rem <= AP_INIT;
                end
            end
        end
    end

    a_r9_precharge_closes: assert property (@(posedge clk) disable iff (rst)
        pre_hit |=> !open_q);

    a_r11_activate_opens: assert property (@(posedge clk) disable iff (rst)
        act_hit |=> open_q);

endmodule

// File: rtl/sdram_err_report.sv
module sdram_err_report
    import sdram_mon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NRULE-1:0]     viol,
    output logic [NRULE-1:0]     err_sticky,
    output logic                 err_pulse,
    output logic [CODE_W-1:0]    err_code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_sticky <= '0;
            err_pulse  <= 1'b0;
            err_code   <= '0;
        end else begin
            err_sticky <= err_sticky | viol;
            err_pulse  <= |viol;
            err_code   <= lowest_rule(viol);
        end
    end

    a_r12_sticky_holds: assert property (@(posedge clk) disable iff (rst)
        ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

    a_r12_code_recorded: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_sticky[err_code]);

endmodule

// File: rtl/sdram_proto_monitor.sv
module sdram_proto_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NBANK     = 4,
    parameter int T_RCD     = 3,
    parameter int T_RRD     = 2,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 5,
    parameter int MRS_GAP   = 2,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic              a10,
    output logic [NRULE-1:0]  err_sticky,
    output logic              err_pulse,
    output logic [CODE_W-1:0] err_code
);
    localparam int T_A  = (T_RCD > T_RRD) ? T_RCD : T_RRD;
    localparam int T_B  = (T_RP > T_RAS) ? T_RP : T_RAS;
    localparam int T_C  = (T_A > T_B) ? T_A : T_B;
    localparam int TMAX = (T_C > MRS_GAP) ? T_C : MRS_GAP;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] CMAX  = '1;
    localparam logic [CW-1:0] RRD_L = CW'(T_RRD);
    localparam logic [CW-1:0] MRS_L = CW'(MRS_GAP);

    op_e              op;
    logic             v_cke;
    logic [CW-1:0]    mrs_cnt, rrd_cnt;
    logic [NBANK-1:0] b_open, b_ap, b_closed, b_reopen, b_rcd, b_ras, b_rp;
    logic [NRULE-1:0] viol;

    sdram_cmd_front u_front (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .op_acc(op), .v_cke(v_cke)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        sdram_bank_tracker #(
            .CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
            .BURST_LEN(BURST_LEN)
        ) u_bank (
            .clk(clk), .rst(rst), .op(op),
            .sel(ba == BA_W'(g)), .a10(a10),
            .open_o(b_open[g]), .ap_busy_o(b_ap[g]),
            .v_closed(b_closed[g]), .v_reopen(b_reopen[g]),
            .v_rcd(b_rcd[g]), .v_ras(b_ras[g]), .v_rp(b_rp[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mrs_cnt <= CMAX;
            rrd_cnt <= CMAX;
        end else begin
            if (mrs_cnt != CMAX) mrs_cnt <= mrs_cnt + 1'b1;
            if (rrd_cnt != CMAX) rrd_cnt <= rrd_cnt + 1'b1;
            if (op == OP_MRS)    mrs_cnt <= CW'(1);
            if (op == OP_ACT)    rrd_cnt <= CW'(1);
        end
    end

    always_comb begin
        viol             = '0;
        viol[RL_CKE]     = v_cke;
        viol[RL_MRS_GAP] = is_real(op) && (mrs_cnt < MRS_L);
        viol[RL_ALLPRE]  = ((op == OP_MRS) || (op == OP_REF)) && (|b_open);
        viol[RL_CLOSED]  = |b_closed;
        viol[RL_REOPEN]  = |b_reopen;
        viol[RL_RCD]     = |b_rcd;
        viol[RL_RRD]     = (op == OP_ACT) && (rrd_cnt < RRD_L);
        viol[RL_RAS]     = |b_ras;
        viol[RL_RP]      = |b_rp;
        viol[RL_APLOCK]  = is_rw(op) && (|b_ap);
    end

    sdram_err_report u_report (
        .clk(clk), .rst(rst), .viol(viol),
        .err_sticky(err_sticky), .err_pulse(err_pulse), .err_code(err_code)
    );

    a_r2_no_state_change_when_suspended: assert property (@(posedge clk) disable iff (rst)
        v_cke |=> $stable(rrd_cnt) || (rrd_cnt == CMAX) || (rrd_cnt == $past(rrd_cnt) + 1'b1));

endmodule

// File: tb/sdram_proto_monitor_test.sv
module sdram_proto_monitor_test;
    localparam int NOP = 0, DSL = 1, ACT = 2, RD = 3, WR = 4, PRE = 5, MRS = 6, REF = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic       a10 = 1'b0;
    logic [9:0] err_sticky;
    logic       err_pulse;
    logic [3:0] err_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        bit         pulse;
        logic [3:0] code;
        string      tag;
    } exp_t;
    exp_t sb[$];

    sdram_proto_monitor uut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
        .err_sticky(err_sticky), .err_pulse(err_pulse), .err_code(err_code)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int op, input int b, input bit ap, input bit ck,
                        input int exp, input string tag);
        exp_t e;
        @(negedge clk);
        cke = ck; ba = b[1:0]; a10 = ap; cs_n = 1'b0;
        case (op)
            DSL:     begin cs_n = 1'b1; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; end
            ACT:     begin ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b1; end
            RD:      begin ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1; end
            WR:      begin ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b0; end
            PRE:     begin ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b0; end
            MRS:     begin ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; end
            REF:     begin ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b1; end
            default: begin ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; end
        endcase
        e.pulse = (exp >= 0);
        e.code  = (exp >= 0) ? exp[3:0] : 4'd0;
        e.tag   = tag;
        sb.push_back(e);
    endtask

    // monitor: compares one result per command, one cycle after its edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                if (e.pulse)
                    check(err_pulse && (err_code == e.code), e.tag,
                          {err_pulse, err_code}, {1'b1, e.code});
                else
                    check(!err_pulse, e.tag, {err_pulse, err_code}, 0);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(err_sticky == 10'h0, "R12 reset sticky", err_sticky, 0);
        check(!err_pulse, "R12 reset pulse", err_pulse, 0);

        step(NOP, 0, 0, 1, -1, "R1 nop");
        step(DSL, 3, 1, 1, -1, "R1 deselect with strobes low");
        // mode-set gap
        step(MRS, 0, 0, 1, -1, "R4 mrs with all closed");
        step(NOP, 0, 0, 1, -1, "R4 nop after mrs");
        step(REF, 0, 0, 1, -1, "R4 refresh at exact gap");
        step(MRS, 0, 0, 1, -1, "R4 second mrs");
        step(RD,  1, 0, 1,  1, "R4 R12 read one cycle after mrs, also closed");
        step(NOP, 0, 0, 1, -1, "R1 idle");
        step(NOP, 0, 0, 1, -1, "R1 idle");
        // activates, rcd, ras, rp
        step(ACT, 0, 0, 1, -1, "R6 first activate");
        step(ACT, 1, 0, 1,  6, "R6 activate too soon");
        step(RD,  1, 0, 1,  5, "R5 read before rcd");
        step(RD,  0, 0, 1, -1, "R5 read at exact rcd");
        step(PRE, 1, 0, 1,  7, "R7 precharge before ras");
        step(ACT, 1, 0, 1,  8, "R8 activate before rp");
        step(NOP, 0, 0, 1, -1, "R1 idle");
        step(REF, 0, 0, 1,  2, "R3 refresh with banks open");
        step(NOP, 0, 0, 1, -1, "R1 idle");
        step(NOP, 0, 0, 1, -1, "R1 idle");
        step(PRE, 2, 1, 1, -1, "R9 precharge all");
        step(RD,  0, 0, 1,  3, "R9 R11 read after precharge all");
        step(NOP, 0, 0, 1, -1, "R1 idle");
        // selective precharge and reopen
        step(ACT, 0, 0, 1, -1, "R8 activate at exact rp");
        step(NOP, 0, 0, 1, -1, "R1 idle");
        step(ACT, 2, 0, 1, -1, "R6 activate at exact rrd");
        step(NOP, 0, 0, 1, -1, "R1 idle");
        step(ACT, 2, 0, 1,  4, "R11 activate open bank");
        step(PRE, 0, 0, 1, -1, "R9 R7 single precharge at exact ras");
        step(RD,  0, 0, 1,  3, "R9 precharged bank closed");
        step(RD,  2, 0, 1, -1, "R9 other bank still open");
        // auto-precharge burst
        step(WR,  2, 1, 1, -1, "R10 write with auto precharge");
        step(NOP, 0, 0, 1, -1, "R10 burst");
        step(RD,  2, 0, 1,  9, "R10 read during burst");
        step(NOP, 0, 0, 1, -1, "R10 burst tail");
        step(ACT, 2, 0, 1,  8, "R10 activate right after burst end");
        // clock enable
        step(NOP, 0, 0, 0, -1, "R2 cke low on nop");
        step(MRS, 0, 0, 1,  0, "R2 mrs after cke low");
        step(RD,  2, 0, 1, -1, "R2 discarded mrs opens no gap");
        step(NOP, 0, 0, 0, -1, "R2 cke low on nop");
        step(ACT, 3, 0, 1,  0, "R2 activate after cke low");
        step(RD,  3, 0, 1,  3, "R2 discarded activate left bank closed");
        step(NOP, 0, 0, 1, -1, "R12 pulse clears");
        step(NOP, 0, 0, 1, -1, "R12 pulse stays clear");

        @(negedge clk);
        wait (sb.size() == 0);
        @(negedge clk);
        check(err_sticky == 10'h3FF, "R12 sticky holds all rules", err_sticky, 10'h3FF);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(err_sticky == 10'h0, "R12 sticky cleared by reset", err_sticky, 0);
        finish_run();
    end

endmodule